// File: doc/BRIEF.md
# Sequencer Clock Ratio Divider

This block turns a sequencer timebase into a family of sync clocks for outside gear. The timebase arrives as a square wave whose rising edges are ticks; 32 ticks make one base period. From that tick stream the block builds a clock at four times the base rate (one period every 8 ticks) and a clock at three times the base rate. The 3x clock comes from a segment counter that wraps after 11 ticks and is also forced back to zero at the start of every 32-tick frame. Each frame therefore holds segments of 11, 11 and 10 ticks: the mean rate is exactly 3x, and the period jitters by one tick.

A ratio select picks which of the two feeds the first clock output. A chain of four divide-by-2 stages then produces the slower outputs. A click output follows the fourth clock output when clicks are enabled. A source select feeds the counters from either the internal timebase or an external (tape playback) tick input. The internal timebase level is echoed on a record output. A stop input holds every counter at zero and forces all clock, click and record outputs low. The running flag output shows the inverse of stop.

All logic runs on one system clock. Both tick inputs pass through two-flop synchronizers, and a rising edge of the selected one becomes a one-cycle tick. A tick input edge shows up on the clock outputs three system clocks after the input rises. The block moves no data stream, so every pin is a plain control or status level with no handshake.

Top module: `seq_ratio_clk`

## Requirements
- R1: `running_o` is always the inverse of `stop_i`.
- R2: While `stop_i` is 1, `cl_o`, `click_o` and `rec_o` are all 0, and ticks arriving meanwhile have no effect on later outputs.
- R3: With `ratio3_i` = 1, take n as the 0-based count of ticks since start and m = n mod 32. Segment position is m for m<11, m-11 for 11<=m<22, and m-22 otherwise. After tick n, `cl_o[0]` is 1 exactly when the position is below 5.
- R4: With `ratio3_i` = 0, after tick n `cl_o[0]` is 1 exactly when n mod 8 is below 4.
- R5: For k = 1..4, `cl_o[k]` toggles on each rising edge of `cl_o[k-1]` and at no other time, so `cl_o[k]` is `cl_o[0]` divided by 2^k.
- R6: `click_o` equals `cl_o[3]` AND `click_en_i`.
- R7: With `src_ext_i` = 1, rising edges of `ext_tick_i` are the ticks and `int_tick_i` is ignored. With `src_ext_i` = 0 the roles swap.
- R8: While running, `rec_o` follows `int_tick_i` two system clocks late, whatever the source select.
- R9: `ratio3_i` is used only at ticks. A change between ticks leaves `cl_o` unchanged until the next tick.
- R10: After stop is released, all counters start from zero. The first tick drives every bit of `cl_o` high.
- R11: The first output change from a tick appears three system clock edges after the tick input rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_i | input | 1 | 1 = sequencer stopped; holds counters and outputs low |
| src_ext_i | input | 1 | 1 = count ext_tick_i, 0 = count int_tick_i |
| ratio3_i | input | 1 | 1 = 3x clock on cl_o[0], 0 = 4x clock |
| click_en_i | input | 1 | Enables the click output |
| int_tick_i | input | 1 | Internal timebase square wave (asynchronous) |
| ext_tick_i | input | 1 | External playback tick square wave (asynchronous) |
| cl_o | output | 5 | Sync clocks: bit 0 the ratio clock, bit k that divided by 2^k |
| click_o | output | 1 | Click drive, cl_o[3] gated by click_en_i |
| rec_o | output | 1 | Synchronized internal timebase for recording |
| running_o | output | 1 | Inverse of stop_i |

## Verification
A frame counter that is off by one, or that misses its wrap, moves the short 10-tick segment of the 3x clock. This shows on `cl_o[0]` within one 32-tick frame as a rising edge at the wrong tick. A divider stage that toggles on the wrong edge changes that output's period, which shows within 2^k rising edges of `cl_o[0]`. Counters not cleared by stop show on the very first tick after restart, when not every clock output rises together. Since every tick is compared against a model of tick count and rising-edge count, a fault is reported at the first tick where it differs.

// File: rtl/seq_ratio_pkg.sv
package seq_ratio_pkg;
  // Default geometry of the timebase and the output family
  localparam int FRAME_TICKS_D = 32;  // ticks per base period
  localparam int SEG_LEN_D     = 11;  // 3x segment length before resync
  localparam int DIV_4X_D      = 8;   // ticks per 4x period (power of 2)
  localparam int N_OUT_D       = 5;   // ratio clock plus divide-by-2 stages
  localparam int CLICK_TAP_D   = 3;   // output index driving the click
  localparam int SYNC_STAGES_D = 2;   // synchronizer depth
endpackage

// File: rtl/seq_tick_front.sv
module seq_tick_front #(
  parameter int SYNC_STAGES = seq_ratio_pkg::SYNC_STAGES_D
) (
  input  logic clk,
  input  logic rst_n,
  input  logic int_tick_i,
  input  logic ext_tick_i,
  input  logic src_ext_i,
  output logic tick_o,
  output logic int_lvl_o
);
  logic [SYNC_STAGES-1:0] int_sr, ext_sr;
  logic sel_lvl, sel_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_sr   <= '0;
      ext_sr   <= '0;
      sel_prev <= 1'b0;
    end else begin
      int_sr   <= {int_sr[SYNC_STAGES-2:0], int_tick_i};
      ext_sr   <= {ext_sr[SYNC_STAGES-2:0], ext_tick_i};
      sel_prev <= sel_lvl;
    end
  end

  assign int_lvl_o = int_sr[SYNC_STAGES-1];
  assign sel_lvl   = src_ext_i ? ext_sr[SYNC_STAGES-1] : int_sr[SYNC_STAGES-1];
  assign tick_o    = sel_lvl & ~sel_prev;

  // R7: a selected input edge yields a tick of exactly one cycle
  assert_tick_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/seq_ratio_gen.sv
module seq_ratio_gen #(
  parameter int FRAME_TICKS = seq_ratio_pkg::FRAME_TICKS_D,
  parameter int SEG_LEN     = seq_ratio_pkg::SEG_LEN_D,
  parameter int DIV_4X      = seq_ratio_pkg::DIV_4X_D
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_i,
  input  logic tick_i,
  input  logic ratio3_i,
  output logic cl0_o,
  output logic rise0_o
);
  localparam int FW  = $clog2(FRAME_TICKS);
  localparam int SW  = $clog2(SEG_LEN);
  localparam int D4W = $clog2(DIV_4X);
  localparam logic [FW-1:0]  FRAME_LAST = FW'(FRAME_TICKS - 1);
  localparam logic [SW-1:0]  SEG_LAST   = SW'(SEG_LEN - 1);
  localparam logic [SW-1:0]  SEG_HALF   = SW'(SEG_LEN / 2);
  localparam logic [D4W-1:0] D4_HALF    = D4W'(DIV_4X / 2);

  logic [FW-1:0] frame_q;  // position of the next tick within the frame
  logic [SW-1:0] seg_q;    // position of the next tick within the 3x segment
  logic          cl0_q;
  logic          next_lvl;

  assign next_lvl = ratio3_i ? (seg_q < SEG_HALF)
                             : (frame_q[D4W-1:0] < D4_HALF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      seg_q   <= '0;
      cl0_q   <= 1'b0;
    end else if (stop_i) begin
      frame_q <= '0;
      seg_q   <= '0;
      cl0_q   <= 1'b0;
    end else if (tick_i) begin
      cl0_q   <= next_lvl;
      frame_q <= (frame_q == FRAME_LAST) ? '0 : frame_q + 1'b1;
      if (frame_q == FRAME_LAST || seg_q == SEG_LAST) seg_q <= '0;
      else                                             seg_q <= seg_q + 1'b1;
    end
  end

  assign cl0_o   = cl0_q;
  assign rise0_o = tick_i & ~stop_i & next_lvl & ~cl0_q;

  // R3: segment counter never passes its wrap value
  assert_seg_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seg_q <= SEG_LAST);
  // R3: the frame wrap re-synchronizes the 3x segment
  assert_frame_resync_R3: assert property (@(posedge clk) disable iff (!rst_n || stop_i)
    (tick_i && frame_q == FRAME_LAST) |=> (seg_q == '0 && frame_q == '0));
  // R2/R10: a cycle of stop leaves all counting state at zero
  assert_stop_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_i) |-> (frame_q == '0 && seg_q == '0 && !cl0_q));
endmodule

// File: rtl/seq_div_chain.sv
module seq_div_chain #(
  parameter int N_OUT = seq_ratio_pkg::N_OUT_D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_i,
  input  logic             cl0_i,
  input  logic             rise0_i,
  output logic [N_OUT-1:0] cl_o
);
  logic [N_OUT-1:1] cl_q;
  logic [N_OUT-2:0] rise;

  assign rise[0] = rise0_i;
  assign cl_o    = {cl_q, cl0_i};

  for (genvar i = 1; i < N_OUT; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cl_q[i] <= 1'b0;
      else if (stop_i) cl_q[i] <= 1'b0;
      else             cl_q[i] <= cl_q[i] ^ rise[i-1];
    end
    if (i < N_OUT - 1) begin : g_carry
      assign rise[i] = rise[i-1] & ~cl_q[i];
    end
    // R5: a stage moves only together with a rising edge of the stage before
    assert_div_step_R5: assert property (@(posedge clk) disable iff (!rst_n || stop_i)
      (!$past(stop_i) && !$stable(cl_q[i])) |-> $rose(cl_o[i-1]));
  end
endmodule

// File: rtl/seq_ratio_clk.sv
module seq_ratio_clk #(
  parameter int FRAME_TICKS = seq_ratio_pkg::FRAME_TICKS_D,
  parameter int SEG_LEN     = seq_ratio_pkg::SEG_LEN_D,
  parameter int DIV_4X      = seq_ratio_pkg::DIV_4X_D,
  parameter int N_OUT       = seq_ratio_pkg::N_OUT_D,
  parameter int CLICK_TAP   = seq_ratio_pkg::CLICK_TAP_D,
  parameter int SYNC_STAGES = seq_ratio_pkg::SYNC_STAGES_D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_i,
  input  logic             src_ext_i,
  input  logic             ratio3_i,
  input  logic             click_en_i,
  input  logic             int_tick_i,
  input  logic             ext_tick_i,
  output logic [N_OUT-1:0] cl_o,
  output logic             click_o,
  output logic             rec_o,
  output logic             running_o
);
  logic             tick, int_lvl, cl0, rise0;
  logic [N_OUT-1:0] cl_raw;

  seq_tick_front #(.SYNC_STAGES(SYNC_STAGES)) front_i (
    .clk(clk), .rst_n(rst_n), .int_tick_i(int_tick_i), .ext_tick_i(ext_tick_i),
    .src_ext_i(src_ext_i), .tick_o(tick), .int_lvl_o(int_lvl));

  seq_ratio_gen #(.FRAME_TICKS(FRAME_TICKS), .SEG_LEN(SEG_LEN), .DIV_4X(DIV_4X)) gen_i (
    .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .tick_i(tick), .ratio3_i(ratio3_i),
    .cl0_o(cl0), .rise0_o(rise0));

  seq_div_chain #(.N_OUT(N_OUT)) chain_i (
    .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .cl0_i(cl0), .rise0_i(rise0),
    .cl_o(cl_raw));

  // R2: stop forces the visible outputs low at once
  assign cl_o      = cl_raw & {N_OUT{~stop_i}};
  assign click_o   = cl_raw[CLICK_TAP] & click_en_i & ~stop_i;
  assign rec_o     = int_lvl & ~stop_i;
  assign running_o = ~stop_i;
endmodule

// File: tb/seq_ratio_clk_tb.sv
module seq_ratio_clk_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic stop_i = 1'b0, src_ext_i = 1'b0, ratio3_i = 1'b0, click_en_i = 1'b0;
  logic int_tick_i = 1'b0, ext_tick_i = 1'b0;
  logic [4:0] cl_o;
  logic click_o, rec_o, running_o;

  int n_chk = 0, n_bad = 0;
  int n_tk = 0, n_rise = 0;
  bit cl0m = 1'b0;
  int seed_dummy;

  always #2 clk = ~clk;

  seq_ratio_clk dut_i (
    .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .src_ext_i(src_ext_i),
    .ratio3_i(ratio3_i), .click_en_i(click_en_i), .int_tick_i(int_tick_i),
    .ext_tick_i(ext_tick_i), .cl_o(cl_o), .click_o(click_o), .rec_o(rec_o),
    .running_o(running_o));

  function automatic bit exp_cl0(bit r3, int n);
    int m, pos;
    m = n % 32;
    if (!r3) return (n % 8) < 4;
    pos = (m < 11) ? m : ((m < 22) ? m - 11 : m - 22);
    return pos < 5;
  endfunction

  function automatic logic [4:0] exp_cl();
    logic [4:0] v;
    v[0] = cl0m;
    for (int k = 1; k < 5; k++)
      v[k] = (n_rise == 0) ? 1'b0 : ((((n_rise - 1) >> (k - 1)) & 1) == 0);
    return v;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_outs(string note);
    logic [4:0] e;
    e = exp_cl();
    chk(ratio3_i ? {"R3 cl0 ", note} : {"R4 cl0 ", note}, int'(cl_o[0]), int'(e[0]));
    chk({"R5 div ", note}, int'(cl_o[4:1]), int'(e[4:1]));
    chk({"R6 click ", note}, int'(click_o), int'(e[3] & click_en_i));
  endtask

  // One square-wave period on one input; checks record echo on the internal input
  task automatic pulse(bit on_ext);
    if (on_ext) ext_tick_i = 1'b1; else int_tick_i = 1'b1;
    repeat (4) @(negedge clk);
    if (!on_ext) chk("R8 rec high", int'(rec_o), int'(!stop_i));
    if (on_ext) ext_tick_i = 1'b0; else int_tick_i = 1'b0;
    repeat (4) @(negedge clk);
    if (!on_ext) chk("R8 rec low", int'(rec_o), 0);
  endtask

  task automatic tick_and_check(string note);
    bit nx;
    pulse(src_ext_i);
    nx = exp_cl0(ratio3_i, n_tk);
    if (nx && !cl0m) n_rise++;
    cl0m = nx;
    n_tk++;
    check_outs(note);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    seed_dummy = $urandom(32'd17);
    repeat (3) @(negedge clk);
    chk("R2 reset cl", int'(cl_o), 0);
    chk("R1 reset run", int'(running_o), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R11: exact latency of the first tick
    int_tick_i = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R11 before third edge", int'(cl_o), 0);
    @(negedge clk);
    chk("R11 at third edge", int'(cl_o), 5'h1f);
    int_tick_i = 1'b0;
    repeat (5) @(negedge clk);
    n_tk = 1; n_rise = 1; cl0m = 1'b1;

    // R4: 4x mode over several periods
    for (int i = 0; i < 40; i++) tick_and_check("4x");
    // R3: 3x mode over three frames, click enabled
    click_en_i = 1'b1;
    ratio3_i = 1'b1;
    stop_i = 1'b1; @(negedge clk);
    chk("R1 stop flag", int'(running_o), 0);
    stop_i = 1'b0; @(negedge clk);
    n_tk = 0; n_rise = 0; cl0m = 1'b0;
    for (int i = 0; i < 96; i++) tick_and_check("3x");

    // R9: ratio change between ticks holds the output
    ratio3_i = ~ratio3_i;
    repeat (6) @(negedge clk);
    chk("R9 hold until tick", int'(cl_o[0]), int'(cl0m));
    tick_and_check("R9 after switch");

    // R7: external source; internal edges ignored
    src_ext_i = 1'b1;
    repeat (3) @(negedge clk);
    pulse(1'b0);
    check_outs("R7 int ignored");
    for (int i = 0; i < 12; i++) tick_and_check("R7 ext");
    src_ext_i = 1'b0;
    repeat (3) @(negedge clk);
    pulse(1'b1);
    check_outs("R7 ext ignored");

    // R2/R10: stop, ignored ticks, restart from zero
    stop_i = 1'b1;
    @(negedge clk);
    chk("R2 cl low", int'(cl_o), 0);
    chk("R2 click low", int'(click_o), 0);
    for (int i = 0; i < 3; i++) pulse(1'b0);
    chk("R1 run low", int'(running_o), 0);
    stop_i = 1'b0;
    @(negedge clk);
    n_tk = 0; n_rise = 0; cl0m = 1'b0;
    chk("R10 zero after release", int'(cl_o), 0);
    tick_and_check("R10 first tick");
    chk("R10 all high", int'(cl_o), 5'h1f);

    // Constrained random mix
    for (int i = 0; i < 400; i++) begin
      case ($urandom % 8)
        0: begin ratio3_i = ~ratio3_i; @(negedge clk); end
        1: begin click_en_i = ~click_en_i; @(negedge clk); check_outs("R6 rand"); end
        2: begin src_ext_i = ~src_ext_i; repeat (3) @(negedge clk); end
        3: begin pulse(~src_ext_i); check_outs("R7 rand ignored"); end
        default: tick_and_check("rand");
      endcase
    end
    chk("R1 final run", int'(running_o), 1);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule